// File: doc/BRIEF.md
# Interrupt Redirection Service Engine

This engine sits between a bank of interrupt input lines and the fabric that carries interrupt messages to the local interrupt controllers of the processors. Each input pin has a redirection entry supplied from outside (the register path is not part of this block). The entry says whether the pin is masked, whether it is edge or level sensitive, which vector to raise, which destination to aim at and in which destination and delivery mode. When a pin has a serviceable request, the engine builds one delivery message from that pin's entry, hands it to the fabric with a valid/ready handshake, and waits for the fabric to report how many targets took the interrupt.

Edge-sensitive pins latch a request on a rising line and lose it once their message has been handed over. Level-sensitive pins are pending while their line is high. Once a level delivery has been accepted, the pin is held off by a remote-in-service flag until an end-of-interrupt carrying the same vector arrives. Pin 0 is always sent in physical mode to a programmable boot processor ID. One designated pin, the real-time-clock line, remembers how many targets took its last interrupt and is not served again until that many end-of-interrupts have come back.

Top module: `irq_redir_engine`

## Requirements
- R1: After reset, msg_valid is 0, and remote_irr, edge_done, pending and rtc_count are all zero.
- R2: A pin whose entry mask bit (bit 21 of the entry) is 1 never produces a message, and its blocked bit is 1 while it is pending; clearing the mask lets the pending request through.
- R3: A message carries the entry's vector (bits 15:8), destination (bits 7:0), destination mode (bit 19), delivery mode (bits 18:16) and trigger mode (bit 20, 1 = level), with msg_level at 1 and msg_shorthand at 0, and all fields stay unchanged while msg_valid is 1 and msg_ready is 0.
- R4: When several pins are eligible, the lowest-numbered pin is sent first, and no new message is offered until the response to the previous one has arrived.
- R5: For an edge pin (bit 20 = 0), a rising line sets its pending bit; the handshake of its message clears pending and sets its edge_done bit; the next rising edge clears edge_done; a line held high is not served twice.
- R6: For a level pin, remote_irr is set when the response reports a nonzero count without error, and stays clear otherwise, in which case the still-high line is served again.
- R7: A level pin with remote_irr set is not served; an end-of-interrupt clears remote_irr on every level pin whose entry vector equals the end-of-interrupt vector, and a line still high is then served again.
- R8: A message for pin 0 always has destination mode 0 (physical) and destination equal to boot_id, whatever its entry holds.
- R9: A response for pin RTC_PIN stores its count in rtc_count, or zero when rsp_err is 1; while rtc_count is nonzero that pin is not served, and each end-of-interrupt whose vector equals that pin's entry vector lowers rtc_count by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NUM_PINS | Raw interrupt input lines |
| entry_tbl | input | NUM_PINS*22 | Redirection entries, pin i at bits [22*i +: 22] |
| boot_id | input | 8 | Destination forced for pin 0 |
| msg_valid | output | 1 | Delivery message offered |
| msg_ready | input | 1 | Fabric takes the message |
| msg_pin | output | clog2(NUM_PINS) | Pin the message belongs to |
| msg_vector | output | 8 | Interrupt vector |
| msg_dest | output | 8 | Destination ID |
| msg_dest_mode | output | 1 | 0 physical, 1 logical |
| msg_deliv | output | 3 | Delivery mode |
| msg_trig | output | 1 | 1 level, 0 edge |
| msg_level | output | 1 | Assert flag, always 1 |
| msg_shorthand | output | 2 | Destination shorthand, always 0 |
| rsp_valid | input | 1 | Response for the message in flight |
| rsp_count | input | CNT_W | Number of targets that accepted |
| rsp_err | input | 1 | Delivery failed |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being ended |
| pending | output | NUM_PINS | Per-pin request status |
| blocked | output | NUM_PINS | Pending but masked |
| remote_irr | output | NUM_PINS | Level pin awaiting end-of-interrupt |
| edge_done | output | NUM_PINS | Edge pin delivered since its last rising edge |
| rtc_count | output | CNT_W | Outstanding acceptances of the designated pin |

## Verification
A stuck or wrongly set remote-in-service flag shows up within a few cycles as a level pin that is either served repeatedly with its line high or never served again after its end-of-interrupt. A lost edge request shows as a missing message, while a request that is not cleared at handover shows as a second message for a line that never fell. A wrong designated-pin counter shows as that pin being served too early or held off after its last end-of-interrupt. Wrong field routing or a missed pin 0 override is visible on the very first message for the affected pin.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam int VEC_W   = 8;
  localparam int DEST_W  = 8;
  localparam int DMODE_W = 3;

  // Entry layout, MSB first: mask, trig, dest_mode, deliv, vector, dest
  typedef struct packed {
    logic               mask;
    logic               trig;       // 1 = level, 0 = edge
    logic               dest_mode;  // 0 = physical, 1 = logical
    logic [DMODE_W-1:0] deliv;
    logic [VEC_W-1:0]   vector;
    logic [DEST_W-1:0]  dest;
  } redir_entry_t;

  localparam int ENTRY_W = $bits(redir_entry_t);

  typedef struct packed {
    logic [VEC_W-1:0]   vector;
    logic [DEST_W-1:0]  dest;
    logic               dest_mode;
    logic [DMODE_W-1:0] deliv;
    logic               trig;
  } redir_msg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } svc_state_t;

  // Pin 0 is always aimed physically at the boot processor
  function automatic redir_msg_t compose_msg(input redir_entry_t e,
                                             input logic         is_pin0,
                                             input logic [DEST_W-1:0] boot);
    redir_msg_t m;
    m.vector    = e.vector;
    m.deliv     = e.deliv;
    m.trig      = e.trig;
    m.dest      = is_pin0 ? boot : e.dest;
    m.dest_mode = is_pin0 ? 1'b0 : e.dest_mode;
    return m;
  endfunction

endpackage

// File: rtl/irq_pin_state.sv
module irq_pin_state
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] line_in,
  input  redir_entry_t        ent [NUM_PINS],
  input  logic [NUM_PINS-1:0] edge_taken,
  input  logic [NUM_PINS-1:0] rirr_set,
  input  logic                eoi_valid,
  input  logic [VEC_W-1:0]    eoi_vector,
  output logic [NUM_PINS-1:0] pending,
  output logic [NUM_PINS-1:0] remote_irr,
  output logic [NUM_PINS-1:0] edge_done
);

  logic [NUM_PINS-1:0] line_q;
  logic [NUM_PINS-1:0] edge_req;
  logic [NUM_PINS-1:0] line_rise;
  logic [NUM_PINS-1:0] eoi_hit;

  assign line_rise = line_in & ~line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_in;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign eoi_hit[i] = eoi_valid && ent[i].trig && (ent[i].vector == eoi_vector);
    assign pending[i] = ent[i].trig ? line_in[i] : edge_req[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        edge_req[i]   <= 1'b0;
        edge_done[i]  <= 1'b0;
        remote_irr[i] <= 1'b0;
      end else begin
        // a new rising edge wins over the handover clear
        if (line_rise[i])        edge_req[i] <= 1'b1;
        else if (edge_taken[i])  edge_req[i] <= 1'b0;

        if (edge_taken[i])       edge_done[i] <= 1'b1;
        else if (line_rise[i])   edge_done[i] <= 1'b0;

        if (rirr_set[i])         remote_irr[i] <= 1'b1;
        else if (eoi_hit[i])     remote_irr[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_PINS = 8,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [NUM_PINS-1:0] eligible,
  output logic                any,
  output logic [PIN_W-1:0]    idx
);

  // lowest set bit wins
  function automatic logic [PIN_W-1:0] lowest_set(input logic [NUM_PINS-1:0] v);
    logic [PIN_W-1:0] r;
    r = '0;
    for (int k = NUM_PINS - 1; k >= 0; k--) begin
      if (v[k]) r = PIN_W'(k);
    end
    return r;
  endfunction

  assign any = |eligible;
  assign idx = lowest_set(eligible);

endmodule

// File: rtl/irq_msg_build.sv
module irq_msg_build
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  redir_entry_t      ent [NUM_PINS],
  input  logic [PIN_W-1:0]  sel,
  input  logic [DEST_W-1:0] boot_id,
  output redir_msg_t        msg,
  output logic              sel_masked
);

  redir_entry_t chosen;

  always_comb begin
    chosen = ent[0];
    for (int k = 0; k < NUM_PINS; k++) begin
      if (sel == PIN_W'(k)) chosen = ent[k];
    end
  end

  assign msg        = compose_msg(chosen, sel == '0, boot_id);
  assign sel_masked = chosen.mask;

endmodule

// File: rtl/irq_redir_engine.sv
module irq_redir_engine
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int CNT_W    = 4,
  parameter int RTC_PIN  = 1,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         line_in,
  input  logic [NUM_PINS*ENTRY_W-1:0] entry_tbl,
  input  logic [DEST_W-1:0]           boot_id,
  output logic                        msg_valid,
  input  logic                        msg_ready,
  output logic [PIN_W-1:0]            msg_pin,
  output logic [VEC_W-1:0]            msg_vector,
  output logic [DEST_W-1:0]           msg_dest,
  output logic                        msg_dest_mode,
  output logic [DMODE_W-1:0]          msg_deliv,
  output logic                        msg_trig,
  output logic                        msg_level,
  output logic [1:0]                  msg_shorthand,
  input  logic                        rsp_valid,
  input  logic [CNT_W-1:0]            rsp_count,
  input  logic                        rsp_err,
  input  logic                        eoi_valid,
  input  logic [VEC_W-1:0]            eoi_vector,
  output logic [NUM_PINS-1:0]         pending,
  output logic [NUM_PINS-1:0]         blocked,
  output logic [NUM_PINS-1:0]         remote_irr,
  output logic [NUM_PINS-1:0]         edge_done,
  output logic [CNT_W-1:0]            rtc_count
);

  redir_entry_t        ent [NUM_PINS];
  logic [NUM_PINS-1:0] mask_bits;
  logic [NUM_PINS-1:0] level_bits;
  logic [NUM_PINS-1:0] rtc_gate;
  logic [NUM_PINS-1:0] eligible;
  logic [NUM_PINS-1:0] edge_taken;
  logic [NUM_PINS-1:0] rirr_set;

  svc_state_t          state;
  redir_msg_t          cur_msg;
  redir_msg_t          new_msg;
  logic [PIN_W-1:0]    cur_pin;
  logic [PIN_W-1:0]    pick_idx;
  logic                pick_any;
  logic                issue_masked;

  // named internal events
  logic ev_issue;
  logic ev_hand;
  logic ev_rsp;
  logic rsp_accept;
  logic rtc_eoi;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_unpack
    assign ent[i]        = entry_tbl[i*ENTRY_W +: ENTRY_W];
    assign mask_bits[i]  = ent[i].mask;
    assign level_bits[i] = ent[i].trig;
    if (i == RTC_PIN) begin : g_rtc
      assign rtc_gate[i] = (rtc_count != '0);
    end else begin : g_norm
      assign rtc_gate[i] = 1'b0;
    end
  end

  assign eligible = pending & ~mask_bits & ~(level_bits & remote_irr) & ~rtc_gate;
  assign blocked  = pending & mask_bits;

  irq_pick #(.NUM_PINS(NUM_PINS)) u_pick (
    .eligible (eligible),
    .any      (pick_any),
    .idx      (pick_idx)
  );

  irq_msg_build #(.NUM_PINS(NUM_PINS)) u_build (
    .ent        (ent),
    .sel        (pick_idx),
    .boot_id    (boot_id),
    .msg        (new_msg),
    .sel_masked (issue_masked)
  );

  assign ev_issue   = (state == ST_IDLE) && pick_any;
  assign ev_hand    = (state == ST_SEND) && msg_ready;
  assign ev_rsp     = (state == ST_WAIT) && rsp_valid;
  assign rsp_accept = ev_rsp && !rsp_err && (rsp_count != '0);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ctl
    assign edge_taken[i] = ev_hand && !cur_msg.trig && (cur_pin == PIN_W'(i));
    assign rirr_set[i]   = rsp_accept && cur_msg.trig && (cur_pin == PIN_W'(i));
  end

  irq_pin_state #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .ent        (ent),
    .edge_taken (edge_taken),
    .rirr_set   (rirr_set),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .pending    (pending),
    .remote_irr (remote_irr),
    .edge_done  (edge_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_pin <= '0;
      cur_msg <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ev_issue) begin
          state   <= ST_SEND;
          cur_pin <= pick_idx;
          cur_msg <= new_msg;
        end
        ST_SEND: if (ev_hand) state <= ST_WAIT;
        ST_WAIT: if (ev_rsp)  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // designated-pin acceptance count
  assign rtc_eoi = eoi_valid && (eoi_vector == ent[RTC_PIN].vector) && (rtc_count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rtc_count <= '0;
    end else if (ev_rsp && (cur_pin == PIN_W'(RTC_PIN))) begin
      rtc_count <= rsp_err ? '0 : rsp_count;
    end else if (rtc_eoi) begin
      rtc_count <= rtc_count - 1'b1;
    end
  end

  assign msg_valid     = (state == ST_SEND);
  assign msg_pin       = cur_pin;
  assign msg_vector    = cur_msg.vector;
  assign msg_dest      = cur_msg.dest;
  assign msg_dest_mode = cur_msg.dest_mode;
  assign msg_deliv     = cur_msg.deliv;
  assign msg_trig      = cur_msg.trig;
  assign msg_level     = 1'b1;
  assign msg_shorthand = 2'b00;

endmodule

// File: rtl/irq_redir_engine_chk.sv
module irq_redir_engine_chk #(
  parameter int NUM_PINS = 8,
  parameter int CNT_W    = 4,
  parameter int RTC_PIN  = 1,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [PIN_W-1:0]    msg_pin,
  input logic [7:0]          msg_vector,
  input logic [7:0]          msg_dest,
  input logic                msg_dest_mode,
  input logic [2:0]          msg_deliv,
  input logic                msg_trig,
  input logic [7:0]          boot_id,
  input logic                ev_issue,
  input logic                issue_masked,
  input logic [PIN_W-1:0]    issue_pin,
  input logic [NUM_PINS-1:0] pending,
  input logic [NUM_PINS-1:0] blocked,
  input logic [NUM_PINS-1:0] remote_irr,
  input logic                rsp_valid,
  input logic [CNT_W-1:0]    rsp_count,
  input logic                rsp_err,
  input logic [CNT_W-1:0]    rtc_count
);

  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |-> !issue_masked); // R2

  AST_BLOCKED_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked & ~pending) == '0); // R2

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)
      && $stable(msg_dest_mode) && $stable(msg_deliv) && $stable(msg_trig) && $stable(msg_pin))); // R3

  AST_PIN0_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_pin == '0) |-> (!msg_dest_mode && msg_dest == boot_id)); // R8

  AST_RIRR_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ((remote_irr & ~$past(remote_irr)) != '0) |-> $past(rsp_valid && !rsp_err && rsp_count != '0)); // R6

  AST_RTC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_issue && issue_pin == PIN_W'(RTC_PIN)) |-> (rtc_count == '0)); // R9

endmodule

bind irq_redir_engine irq_redir_engine_chk #(
  .NUM_PINS (NUM_PINS),
  .CNT_W    (CNT_W),
  .RTC_PIN  (RTC_PIN)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .msg_valid     (msg_valid),
  .msg_ready     (msg_ready),
  .msg_pin       (msg_pin),
  .msg_vector    (msg_vector),
  .msg_dest      (msg_dest),
  .msg_dest_mode (msg_dest_mode),
  .msg_deliv     (msg_deliv),
  .msg_trig      (msg_trig),
  .boot_id       (boot_id),
  .ev_issue      (ev_issue),
  .issue_masked  (issue_masked),
  .issue_pin     (pick_idx),
  .pending       (pending),
  .blocked       (blocked),
  .remote_irr    (remote_irr),
  .rsp_valid     (rsp_valid),
  .rsp_count     (rsp_count),
  .rsp_err       (rsp_err),
  .rtc_count     (rtc_count)
);

// File: tb/irq_redir_engine_test.sv
`timescale 1ns/1ps
module irq_redir_engine_test;
  import irq_redir_pkg::*;

  localparam int N     = 8;
  localparam int CW    = 4;
  localparam int RTC   = 1;
  localparam int PW    = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      line_in = '0;
  logic [ENTRY_W-1:0] tbl [N];
  logic [N*ENTRY_W-1:0] entry_tbl;
  logic [7:0]        boot_id = 8'h5A;
  logic              msg_valid, msg_ready = 1'b0;
  logic [PW-1:0]     msg_pin;
  logic [7:0]        msg_vector, msg_dest;
  logic              msg_dest_mode, msg_trig, msg_level;
  logic [2:0]        msg_deliv;
  logic [1:0]        msg_shorthand;
  logic              rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [CW-1:0]     rsp_count = '0;
  logic              eoi_valid = 1'b0;
  logic [7:0]        eoi_vector = '0;
  logic [N-1:0]      pending, blocked, remote_irr, edge_done;
  logic [CW-1:0]     rtc_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) entry_tbl[i*ENTRY_W +: ENTRY_W] = tbl[i];
  end

  irq_redir_engine #(.NUM_PINS(N), .CNT_W(CW), .RTC_PIN(RTC)) uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .entry_tbl(entry_tbl), .boot_id(boot_id),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_pin(msg_pin), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .msg_dest_mode(msg_dest_mode), .msg_deliv(msg_deliv), .msg_trig(msg_trig),
    .msg_level(msg_level), .msg_shorthand(msg_shorthand), .rsp_valid(rsp_valid),
    .rsp_count(rsp_count), .rsp_err(rsp_err), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .pending(pending), .blocked(blocked), .remote_irr(remote_irr), .edge_done(edge_done),
    .rtc_count(rtc_count)
  );

  // entry layout: [21] mask, [20] trig (1 level), [19] dest mode, [18:16] delivery, [15:8] vector, [7:0] dest
  function automatic logic [21:0] mk(input bit m, input bit t, input bit dm,
                                     input logic [2:0] dl, input logic [7:0] v, input logic [7:0] d);
    return {m, t, dm, dl, v, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic deliver(input int pin, input int cnt, input bit err);
    int waited;
    logic [7:0] ev, ed;
    logic edm;
    waited = 0;
    while (!msg_valid && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    chk(msg_valid, "R4 message expected", int'(msg_valid), 1);
    ev  = tbl[pin][15:8];
    ed  = (pin == 0) ? boot_id : tbl[pin][7:0];
    edm = (pin == 0) ? 1'b0 : tbl[pin][19];
    chk(msg_pin == PW'(pin), "R4 pin order", int'(msg_pin), pin);
    chk(msg_vector == ev, "R3 vector", int'(msg_vector), int'(ev));
    chk(msg_dest == ed, "R3/R8 destination", int'(msg_dest), int'(ed));
    chk(msg_dest_mode == edm, "R3/R8 destination mode", int'(msg_dest_mode), int'(edm));
    chk(msg_deliv == tbl[pin][18:16], "R3 delivery mode", int'(msg_deliv), int'(tbl[pin][18:16]));
    chk(msg_trig == tbl[pin][20], "R3 trigger", int'(msg_trig), int'(tbl[pin][20]));
    chk(msg_level == 1'b1 && msg_shorthand == 2'b00, "R3 level/shorthand",
        int'({msg_level, msg_shorthand}), 4);
    cyc(2);
    chk(msg_valid && msg_vector == ev && msg_dest == ed, "R3 held while not ready",
        int'(msg_vector), int'(ev));
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    chk(!msg_valid, "R4 one outstanding", int'(msg_valid), 0);
    rsp_valid = 1'b1;
    rsp_count = CW'(cnt);
    rsp_err   = err;
    @(negedge clk);
    rsp_valid = 1'b0;
    rsp_err   = 1'b0;
    rsp_count = '0;
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_valid  = 1'b1;
    eoi_vector = v;
    @(negedge clk);
    eoi_valid  = 1'b0;
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen;
    seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk(!seen, tag, int'(seen), 0);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) tbl[i] = '0;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!msg_valid, "R1 msg_valid", int'(msg_valid), 0);
    chk(remote_irr == '0 && edge_done == '0 && pending == '0, "R1 state bits",
        int'({remote_irr, edge_done, pending}), 0);
    chk(rtc_count == '0, "R1 rtc_count", int'(rtc_count), 0);

    // edge sweep: all pins at once, served in ascending order
    for (int p = 0; p < N; p++) tbl[p] = mk(0, 0, 1, 3'(p), 8'(8'h20 + p), 8'(8'h10 + 3*p));
    line_in = '1;
    for (int p = 0; p < N; p++) begin
      deliver(p, 0, 1'b0);
      chk(!pending[p], "R5 pending cleared", int'(pending[p]), 0);
      chk(edge_done[p], "R5 edge_done set", int'(edge_done[p]), 1);
    end
    quiet(10, "R5 held line not served twice");
    line_in = '0;
    cyc(2);
    line_in[3] = 1'b1;
    cyc(2);
    chk(!edge_done[3], "R5 edge_done cleared by rise", int'(edge_done[3]), 0);
    deliver(3, 0, 1'b0);
    line_in = '0;

    // pin 0 override with a new boot id
    boot_id = 8'hC3;
    tbl[0] = mk(0, 0, 1, 3'd5, 8'h77, 8'h99);
    cyc(1);
    line_in[0] = 1'b1;
    deliver(0, 1, 1'b0);
    line_in[0] = 1'b0;

    // level pins and end-of-interrupt
    tbl[2] = mk(0, 1, 1, 3'd0, 8'h40, 8'h02);
    tbl[3] = mk(0, 1, 0, 3'd1, 8'h40, 8'h03);
    tbl[4] = mk(0, 1, 1, 3'd0, 8'h41, 8'h04);
    cyc(2);
    line_in[4:2] = 3'b111;
    deliver(2, 1, 1'b0);
    chk(remote_irr[2], "R6 remote_irr on accept", int'(remote_irr[2]), 1);
    deliver(3, 0, 1'b0);
    chk(!remote_irr[3], "R6 no remote_irr on zero count", int'(remote_irr[3]), 0);
    deliver(3, 2, 1'b0);
    deliver(4, 1, 1'b0);
    chk(remote_irr[4:2] == 3'b111, "R6 all level pins in service", int'(remote_irr[4:2]), 7);
    quiet(10, "R7 in-service level pins held off");
    eoi(8'h40);
    chk(remote_irr[4:2] == 3'b100, "R7 eoi clears matching vector", int'(remote_irr[4:2]), 4);
    deliver(2, 1, 1'b0);
    deliver(3, 1, 1'b0);
    line_in[4:2] = 3'b000;
    eoi(8'h40);
    eoi(8'h41);
    chk(remote_irr == '0, "R7 all cleared", int'(remote_irr), 0);
    quiet(5, "R7 low lines not served");

    // mask
    tbl[5] = mk(1, 1, 1, 3'd0, 8'h55, 8'h05);
    cyc(1);
    line_in[5] = 1'b1;
    cyc(2);
    chk(blocked[5], "R2 blocked flag", int'(blocked[5]), 1);
    quiet(15, "R2 masked pin silent");
    tbl[5][21] = 1'b0;
    deliver(5, 1, 1'b0);
    line_in[5] = 1'b0;
    eoi(8'h55);

    // designated pin count
    tbl[1] = mk(0, 0, 1, 3'd0, 8'h33, 8'h07);
    cyc(2);
    line_in[1] = 1'b1;
    deliver(1, 3, 1'b0);
    chk(rtc_count == 4'd3, "R9 count stored", int'(rtc_count), 3);
    line_in[1] = 1'b0;
    cyc(1);
    line_in[1] = 1'b1;
    cyc(2);
    chk(pending[1], "R9 request pending", int'(pending[1]), 1);
    quiet(10, "R9 pin held while count nonzero");
    eoi(8'h33);
    chk(rtc_count == 4'd2, "R9 eoi decrement", int'(rtc_count), 2);
    eoi(8'h33);
    quiet(4, "R9 still held at count 1");
    eoi(8'h33);
    deliver(1, 5, 1'b1);
    chk(rtc_count == 4'd0, "R9 error stores zero", int'(rtc_count), 0);
    line_in[1] = 1'b0;
    cyc(3);

    done = 1'b1;
    finish_run();
  end

endmodule